// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial characters from one line input. A system-supplied clock enable marks the oversampling rate, which is sixteen ticks per bit by default. The line is resynchronised through a short flop chain. A falling edge on the idle-high line starts a candidate start bit. The candidate is confirmed by a majority vote of three samples taken around mid-bit, and a majority of ones sends the receiver back to idle. Each data bit is then recovered by the same three-sample vote and shifted in least significant bit first. The stop bit is voted as well. The character is handed to a holding register at the stop bit's decision tick, whether or not the stop bit was valid. In nine-bit mode the extra data bit is presented on its own output.

The host side has a holding register with three flags: a receive-complete flag, a framing error flag and a buffered overrun flag. A character that completes while the holding register is still unread is discarded, and the overrun is only noted as pending. The pending overrun becomes visible on the overrun output when the host pulses the read strobe to take the unread byte. That read also clears the receive-complete flag.

The control state machine has four states. IDLE waits for a falling edge on a tick. START votes on the start bit, goes back to IDLE on a majority of ones, and moves to DATA at the end of the bit period. DATA collects eight or nine bits and then moves to STOP. STOP votes on the stop bit, delivers the character and returns to IDLE at the decision tick. Dropping the enable sends any state back to IDLE.

Top module: `sercom_rx`

## Requirements
- R1: After reset, rx_done, frame_err and overrun are 0, rx_data is 0 and the receiver is idle.
- R2: Each data bit takes the value held by at least two of its samples at oversample ticks 8, 9 and 10 of the bit period, counting the start-detecting tick as tick 1 of the start bit. A single disagreeing sample does not change the bit.
- R3: If the majority of the three start-bit samples is 1, the receiver returns to idle and delivers no character.
- R4: In eight-bit mode (nine_bit = 0), eight data bits are received least significant bit first. At the stop bit's tick 10 they are placed on rx_data and rx_done goes to 1.
- R5: In nine-bit mode (nine_bit = 1), nine data bits are received. The first eight go to rx_data and the ninth goes to rx_bit8. In eight-bit mode rx_bit8 is 0.
- R6: When two or more stop-bit samples are 0, frame_err is 1 for the delivered character, and the data is still delivered with rx_done set. A valid stop bit gives frame_err 0.
- R7: A single-cycle rd_stb while rx_done is 1 clears rx_done.
- R8: A character that completes while rx_done is 1 is discarded and rx_data keeps the unread byte. The overrun output does not change until the next rd_stb of the unread byte, which sets it to 1.
- R9: A read of a byte with no pending overrun sets overrun back to 0.
- R10: While rx_en is 0 the receiver is held idle and line activity delivers nothing. A partial character is discarded when rx_en drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects nine data bits per character |
| os_tick | input | 1 | Oversampling clock enable, one pulse per tick |
| line_in | input | 1 | Serial line, idle high |
| rd_stb | input | 1 | Host read pulse for the holding register |
| rx_data | output | DATA_W (8) | Received data byte |
| rx_bit8 | output | 1 | Ninth received bit |
| rx_done | output | 1 | Receive complete, unread byte held |
| frame_err | output | 1 | Stop bit of the held character was invalid |
| overrun | output | 1 | Buffered overrun flag |

## Verification
The assertions assume the following about the inputs:
- os_tick is a single-cycle pulse, with ticks spaced further apart than the synchroniser depth, so each sample reflects a settled line value.
- nine_bit is held constant while a character is in flight.
- rd_stb is a single-cycle pulse.

The stimulus keeps within these limits. Ticks come every four clocks, and each line change is made three clocks before the next tick. The width mode is changed only while the line is idle, and reads are one-clock pulses issued between characters.

// File: rtl/sercom_rx_pkg.sv
package sercom_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/sercom_rx_sync.sv
module sercom_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sercom_rx_vote.sv
module sercom_rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic bit_in,
    output logic maj
);
    logic [1:0] smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   smp_q <= 2'b11;
        else if (cap) smp_q <= {smp_q[0], bit_in};
    end

    // two stored samples plus the live third one
    assign maj = (smp_q[1] & smp_q[0]) | (smp_q[1] & bit_in) | (smp_q[0] & bit_in);
endmodule

// File: rtl/sercom_rx_ctrl.sv
module sercom_rx_ctrl
    import sercom_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int MID     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              os_tick,
    input  logic              line,
    output logic              done_pulse,
    output logic              stop_ok,
    output logic [DATA_W-1:0] char_data,
    output logic              char_bit8,
    output rx_state_e         state_o
);
    localparam int CNT_W = $clog2(OS_RATE) + 1;
    localparam int BC_W  = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] IDX_A   = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] IDX_B   = CNT_W'(MID);
    localparam logic [CNT_W-1:0] IDX_C   = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] IDX_END = CNT_W'(OS_RATE);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, idx;
    logic [BC_W-1:0]   bc_q, nbits;
    logic [DATA_W:0]   sh_q;
    logic              prev_q;
    logic              cap, dec, fin, fall, maj;

    assign idx   = cnt_q + 1'b1;
    assign cap   = os_tick && (state_q != ST_IDLE) && (idx == IDX_A || idx == IDX_B);
    assign dec   = os_tick && (state_q != ST_IDLE) && (idx == IDX_C);
    assign fin   = os_tick && (idx == IDX_END);
    assign fall  = os_tick && prev_q && !line;
    assign nbits = nine_bit ? BC_W'(DATA_W + 1) : BC_W'(DATA_W);

    sercom_rx_vote u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .bit_in (line),
        .maj    (maj)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fall)                 state_d = ST_START;
            ST_START: if (dec && maj)           state_d = ST_IDLE;
                      else if (fin)             state_d = ST_DATA;
            ST_DATA:  if (fin && bc_q == nbits) state_d = ST_STOP;
            ST_STOP:  if (dec)                  state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
        if (!rx_en) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, shifter and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bc_q   <= '0;
            sh_q   <= '0;
            prev_q <= 1'b1;
        end else begin
            if (os_tick) prev_q <= line;
            if (!rx_en) begin
                cnt_q <= '0;
                bc_q  <= '0;
            end else if (state_q == ST_IDLE) begin
                bc_q <= '0;
                if (os_tick) cnt_q <= fall ? CNT_W'(1) : '0;
            end else begin
                if (os_tick) begin
                    if (state_d == ST_IDLE || fin) cnt_q <= '0;
                    else                           cnt_q <= idx;
                end
                if (state_q == ST_DATA && dec) begin
                    sh_q <= {maj, sh_q[DATA_W:1]};
                    bc_q <= bc_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        done_pulse = (state_q == ST_STOP) && dec && rx_en;
        stop_ok    = maj;
        char_data  = nine_bit ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
        char_bit8  = nine_bit & sh_q[DATA_W];
        state_o    = state_q;
    end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int MID         = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              os_tick,
    input  logic              line_in,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_done,
    output logic              frame_err,
    output logic              overrun
);
    logic              line_s, done_pulse, stop_ok, char_bit8;
    logic [DATA_W-1:0] char_data;
    rx_state_e         state;

    logic [DATA_W-1:0] data_q;
    logic              bit8_q, done_q, fe_q, ovr_pend_q, ovr_q;

    sercom_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    sercom_rx_ctrl #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .MID(MID)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .os_tick    (os_tick),
        .line       (line_s),
        .done_pulse (done_pulse),
        .stop_ok    (stop_ok),
        .char_data  (char_data),
        .char_bit8  (char_bit8),
        .state_o    (state)
    );

    // holding register and host flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            bit8_q     <= 1'b0;
            done_q     <= 1'b0;
            fe_q       <= 1'b0;
            ovr_pend_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            if (rd_stb && done_q) begin
                done_q     <= 1'b0;
                ovr_q      <= ovr_pend_q;
                ovr_pend_q <= 1'b0;
            end
            if (done_pulse) begin
                if (done_q && !rd_stb) begin
                    ovr_pend_q <= 1'b1;
                end else begin
                    data_q <= char_data;
                    bit8_q <= char_bit8;
                    fe_q   <= !stop_ok;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign rx_data   = data_q;
    assign rx_bit8   = bit8_q;
    assign rx_done   = done_q;
    assign frame_err = fe_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/sercom_rx_chk.sv
module sercom_rx_chk
    import sercom_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_stb,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_data,
    input logic              frame_err,
    input logic              overrun,
    input rx_state_e         state
);
    AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE); // R10
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(state) == ST_STOP); // R4
    AST_DONE_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done) |-> $past(rd_stb)); // R7
    AST_HELD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rd_stb) |=> $stable(rx_data)); // R8
    AST_OVR_MOVES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(overrun)); // R8
    AST_FE_WITH_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_err) |-> rx_done); // R6
endmodule

bind sercom_rx sercom_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rd_stb    (rd_stb),
    .rx_done   (rx_done),
    .rx_data   (rx_data),
    .frame_err (frame_err),
    .overrun   (overrun),
    .state     (state)
);

// File: tb/sercom_rx_bench.sv
module sercom_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       os_tick = 1'b0;
    logic       line_in = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_done, frame_err, overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercom_rx u_sercom_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .nine_bit  (nine_bit),
        .os_tick   (os_tick),
        .line_in   (line_in),
        .rd_stb    (rd_stb),
        .rx_data   (rx_data),
        .rx_bit8   (rx_bit8),
        .rx_done   (rx_done),
        .frame_err (frame_err),
        .overrun   (overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one oversample tick with the line held at b
    task automatic drive(input logic b);
        line_in = b;
        repeat (3) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1);
    endtask

    // one bit period; gpos (1..16) flips a single tick, 0 for none
    task automatic send_bit(input logic v, input int gpos);
        for (int k = 1; k <= 16; k++) drive((k == gpos) ? ~v : v);
    endtask

    task automatic send_char(input logic [8:0] val, input int nbits, input logic stop_v, input int gpos);
        send_bit(1'b0, 0);
        for (int i = 0; i < nbits; i++) send_bit(val[i], gpos);
        send_bit(stop_v, 0);
        idle(3);
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 rx_done", rx_done, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 overrun", overrun, 0);
    endtask

    task automatic t_basic8();
        send_char(9'h0A5, 8, 1'b1, 0);
        check("R4 data", rx_data, 8'hA5);
        check("R4 done", rx_done, 1);
        check("R6 fe clear", frame_err, 0);
        check("R5 bit8 zero in 8-bit", rx_bit8, 0);
        host_read();
        check("R7 done cleared", rx_done, 0);
        check("R9 overrun stays 0", overrun, 0);
    endtask

    task automatic t_vote();
        send_char(9'h03C, 8, 1'b1, 9);
        check("R2 glitch tick 9", rx_data, 8'h3C);
        host_read();
        send_char(9'h0C3, 8, 1'b1, 8);
        check("R2 glitch tick 8", rx_data, 8'hC3);
        host_read();
        send_char(9'h05A, 8, 1'b1, 10);
        check("R2 glitch tick 10", rx_data, 8'h5A);
        host_read();
    endtask

    task automatic t_nine();
        nine_bit = 1'b1;
        idle(2);
        send_char(9'h15A, 9, 1'b1, 0);
        check("R5 data", rx_data, 8'h5A);
        check("R5 bit8 one", rx_bit8, 1);
        host_read();
        send_char(9'h0FF, 9, 1'b1, 0);
        check("R5 data ff", rx_data, 8'hFF);
        check("R5 bit8 zero", rx_bit8, 0);
        host_read();
        nine_bit = 1'b0;
        idle(2);
    endtask

    task automatic t_frame();
        send_char(9'h081, 8, 1'b0, 0);
        check("R6 fe set", frame_err, 1);
        check("R6 data delivered", rx_data, 8'h81);
        check("R6 done set", rx_done, 1);
        host_read();
        idle(4);
        send_char(9'h07E, 8, 1'b1, 0);
        check("R6 fe clears", frame_err, 0);
        check("R6 next data", rx_data, 8'h7E);
        host_read();
    endtask

    task automatic t_false_start();
        for (int k = 1; k <= 5; k++) drive(1'b0);
        idle(40);
        check("R3 no delivery", rx_done, 0);
        check("R3 data unchanged", rx_data, 8'h7E);
        send_char(9'h024, 8, 1'b1, 0);
        check("R3 recovers", rx_data, 8'h24);
        host_read();
    endtask

    task automatic t_overrun();
        send_char(9'h011, 8, 1'b1, 0);
        send_char(9'h022, 8, 1'b1, 0);
        check("R8 held byte kept", rx_data, 8'h11);
        check("R8 overrun hidden", overrun, 0);
        host_read();
        check("R8 overrun shown", overrun, 1);
        check("R8 done cleared", rx_done, 0);
        send_char(9'h033, 8, 1'b1, 0);
        check("R8 next data", rx_data, 8'h33);
        host_read();
        check("R9 overrun cleared", overrun, 0);
    endtask

    task automatic t_disable();
        send_bit(1'b0, 0);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
        @(negedge clk);
        rx_en = 1'b0;
        for (int i = 0; i < 5; i++) send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_char(9'h0F0, 8, 1'b1, 0);
        check("R10 nothing while off", rx_done, 0);
        check("R10 data kept", rx_data, 8'h33);
        rx_en = 1'b1;
        idle(20);
        check("R10 partial dropped", rx_done, 0);
        send_char(9'h096, 8, 1'b1, 0);
        check("R10 resumes", rx_data, 8'h96);
        host_read();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        rx_en = 1'b1;
        idle(4);
        t_basic8();
        t_vote();
        t_nine();
        t_frame();
        t_false_start();
        t_overrun();
        t_disable();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule